// File: doc/BRIEF.md
# Reset Pin Source Discriminator

This block owns a shared, open-drain reset pin and works out where each reset came from. A reset can be started by a watchdog timeout request, by a clock-failure request, or by something outside the chip pulling the pin low. Whatever starts it, the block pulls the pin low itself for a fixed number of bus-clock ticks, lets go, waits a fixed number of ticks more, and then looks at the pin again. If the pin is still low, some outside agent is holding it, and the reset is reported as external. If it has come back high, the reset is reported as internal, together with which internal source fired.

The pin input passes through a synchronizer before any decision uses it. System reset stays asserted from the start of the sequence to its end. If an outside agent is still holding the pin, system reset stays asserted until the pin is seen high. An asynchronous power-on input restarts the sequence and records a power-on cause. The bus clock is given as a one-cycle enable `e_tick` on the fast clock. Pulses of `e_tick` must be at least three fast-clock cycles apart, so that the synchronized pin has settled before it is sampled.

The state machine has four states:
- `ST_IDLE`: waiting.
- `ST_DRIVE`: the pin is pulled low.
- `ST_RELEASE`: the pin is released and the block waits for the sample.
- `ST_HOLD`: the pin is held low from outside.

It has six transitions:
- IDLE→DRIVE: a request or a low pin.
- DRIVE→RELEASE: on the last drive tick.
- RELEASE→IDLE: the sample is high.
- RELEASE→HOLD: the sample is low.
- HOLD→IDLE: the synchronized pin is high.
- Power-on: any state→DRIVE.

Top module: `rst_pin_arbiter`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1, `pin_drive_low` is 1 and `rst_cause` is 2'b00. The cause encoding is: 00 power-on, 01 external, 10 watchdog, 11 clock monitor.
- R2: Once a sequence starts, `pin_drive_low` stays high for exactly DRIVE_TICKS (4) `e_tick` pulses. It falls right after the clock edge that takes the fourth pulse.
- R3: After the drive ends, the pin is sampled on the SAMPLE_TICKS-th (2nd) `e_tick`. `sys_rst` stays high throughout drive and wait. When the sample is high, `sys_rst` falls at that same edge.
- R4: When the sample is low, `rst_cause` becomes 01, even if an internal request started the sequence. `sys_rst` stays high while the pin is held low. It falls on the third clock edge after the pin returns high.
- R5: When the sample is high after a watchdog request, `rst_cause` becomes 2'b10. After a clock-monitor request it becomes 2'b11.
- R6: A watchdog request and a clock-monitor request in the same idle cycle are recorded as watchdog (2'b10).
- R7: Requests that arrive while a sequence is running are ignored. The cause, the drive length and the wait length are unchanged, and no second sequence follows.
- R8: A low pin seen through the two-flop synchronizer while idle starts a sequence. A pin pulse that has ended by the sample is still reported as external (01).
- R9: After `por_n` rises, the full drive-and-wait sequence runs. The cause stays 2'b00 whatever the sample shows.
- R10: Between sequences, `rst_cause` holds its last value and `sys_rst` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| e_tick | input | 1 | One-cycle bus-clock enable |
| pin_in | input | 1 | Level read back from the reset pin |
| wdog_req | input | 1 | Watchdog timeout request |
| clkmon_req | input | 1 | Clock-failure request |
| pin_drive_low | output | 1 | Enable for the open-drain pull-down of the pin |
| sys_rst | output | 1 | Reset to the rest of the chip |
| rst_cause | output | 2 | Recorded source of the last reset |

## Verification
Two functions can coincide in one cycle, and the bench provokes each pairing on purpose.

The first pairing is source capture against source capture. The watchdog and clock-monitor requests are pulsed together in an idle cycle, and the bench expects the watchdog code.

The second pairing is internal request against outside hold. A watchdog request is raised in the same cycle that the modelled outside agent starts holding the pin low, and the hold lasts past the sample. The bench judges this case by the external code and by `sys_rst` never dropping while the pin is held.

A third set of cases injects requests during the drive and wait phases. These confirm that capture is blocked there, and that no second sequence follows.

// File: rtl/rstsrc_pkg.sv
package rstsrc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRIVE   = 2'd1,
        ST_RELEASE = 2'd2,
        ST_HOLD    = 2'd3
    } arb_state_t;

    typedef enum logic [1:0] {
        CAUSE_POWER = 2'b00,
        CAUSE_EXT   = 2'b01,
        CAUSE_WDOG  = 2'b10,
        CAUSE_CMON  = 2'b11
    } cause_t;

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stg;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("rst_pin_sync needs at least two stages");
        end
    endgenerate

    // Reset value is "pin high" so no spurious trigger follows power-on.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '1;
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

    // Output must lag the preceding stage by exactly one clock (R8).
    p_sync_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q == $past(stg[STAGES-2]));

endmodule

// File: rtl/rst_tick_counter.sv
module rst_tick_counter #(
    parameter  int MAX_COUNT = 4,
    localparam int CW        = $clog2(MAX_COUNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          last
);

    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (tick) begin
            count <= count + CW'(1);
        end
    end

    assign last = tick && (count == (limit - CW'(1)));

    // Counter is cleared on every phase change, so it stays below the longest phase (R2).
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count < CW'(MAX_COUNT));

endmodule

// File: rtl/rst_cause_resolve.sv
module rst_cause_resolve
    import rstsrc_pkg::*;
(
    input  cause_t src,
    input  logic   sample_high,
    output cause_t cause
);

    // Power-on outranks the sample; a low sample outranks any internal source.
    always_comb begin
        if (src == CAUSE_POWER) begin
            cause = CAUSE_POWER;
        end else if (!sample_high) begin
            cause = CAUSE_EXT;
        end else begin
            cause = src;
        end
    end

endmodule

// File: rtl/rst_pin_arbiter.sv
module rst_pin_arbiter
    import rstsrc_pkg::*;
#(
    parameter int DRIVE_TICKS  = 4,
    parameter int SAMPLE_TICKS = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       e_tick,
    input  logic       pin_in,
    input  logic       wdog_req,
    input  logic       clkmon_req,
    output logic       pin_drive_low,
    output logic       sys_rst,
    output logic [1:0] rst_cause
);

    localparam int MAXT = (DRIVE_TICKS > SAMPLE_TICKS) ? DRIVE_TICKS : SAMPLE_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    arb_state_t    state_q, state_d;
    cause_t        src_q, src_d;
    cause_t        cause_q, cause_d;
    cause_t        resolved;
    logic          pin_s;
    logic          tick_last;
    logic          cnt_clr;
    logic          cnt_tick;
    logic [CW-1:0] cnt_limit;

    rst_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    rst_tick_counter #(
        .MAX_COUNT (MAXT)
    ) u_ticks (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (cnt_clr),
        .tick  (cnt_tick),
        .limit (cnt_limit),
        .last  (tick_last)
    );

    rst_cause_resolve u_resolve (
        .src         (src_q),
        .sample_high (pin_s),
        .cause       (resolved)
    );

    // Phase timing: the counter only runs in the two timed phases.
    assign cnt_tick  = e_tick && ((state_q == ST_DRIVE) || (state_q == ST_RELEASE));
    assign cnt_clr   = (state_d != state_q);
    assign cnt_limit = (state_q == ST_DRIVE) ? CW'(DRIVE_TICKS) : CW'(SAMPLE_TICKS);

    // Next-state and capture logic.
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        cause_d = cause_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wdog_req) begin
                    state_d = ST_DRIVE;
                    src_d   = CAUSE_WDOG;
                end else if (clkmon_req) begin
                    state_d = ST_DRIVE;
                    src_d   = CAUSE_CMON;
                end else if (!pin_s) begin
                    state_d = ST_DRIVE;
                    src_d   = CAUSE_EXT;
                end
            end
            ST_DRIVE: begin
                if (tick_last) begin
                    state_d = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (tick_last) begin
                    cause_d = resolved;
                    state_d = pin_s ? ST_IDLE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (pin_s) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register: power-on restarts the sequence with a power-on source.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_DRIVE;
            src_q   <= CAUSE_POWER;
            cause_q <= CAUSE_POWER;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            cause_q <= cause_d;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        pin_drive_low = 1'b0;
        sys_rst       = 1'b1;
        unique case (state_q)
            ST_IDLE:    sys_rst = 1'b0;
            ST_DRIVE:   pin_drive_low = 1'b1;
            ST_RELEASE: pin_drive_low = 1'b0;
            ST_HOLD:    pin_drive_low = 1'b0;
            default:    sys_rst = 1'b1;
        endcase
    end

    assign rst_cause = cause_q;

    // R3: the pin is never pulled while the chip is out of reset.
    p_drive_under_rst_r3: assert property (@(posedge clk) disable iff (!por_n)
        pin_drive_low |-> sys_rst);

    // R2: the pull-down is released only by a bus tick.
    p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pin_drive_low) |-> $past(e_tick));

    // R3: the wait phase ends only on a bus tick.
    p_sample_on_tick_r3: assert property (@(posedge clk) disable iff (!por_n)
        (($past(state_q) == ST_RELEASE) && (state_q != ST_RELEASE)) |-> $past(e_tick));

    // R4: reset held while the synchronized pin is still low.
    p_hold_keeps_rst_r4: assert property (@(posedge clk) disable iff (!por_n)
        ((state_q == ST_HOLD) && !pin_s) |=> sys_rst);

    // R7: the captured source cannot change once a sequence runs.
    p_busy_ignores_req_r7: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != ST_IDLE) |=> ($stable(src_q) || ($past(state_q) == ST_IDLE)));

    // R10: the reported cause is frozen while idle.
    p_cause_stable_r10: assert property (@(posedge clk) disable iff (!por_n)
        ((state_q == ST_IDLE) && ($past(state_q) == ST_IDLE)) |-> $stable(rst_cause));

endmodule

// File: tb/tb_rst_pin_arbiter.sv
`timescale 1ns/1ps
module tb_rst_pin_arbiter;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       wdog_req = 1'b0;
    logic       clkmon_req = 1'b0;
    logic       ext_low = 1'b0;
    logic [1:0] phase = 2'd0;
    logic       e_tick;
    logic       pin_in;
    logic       pin_drive_low;
    logic       sys_rst;
    logic [1:0] rst_cause;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) phase <= phase + 2'd1;
    assign e_tick = (phase == 2'd3);

    // Open-drain pin: low if the block or the outside agent pulls it.
    assign pin_in = !(pin_drive_low || ext_low);

    rst_pin_arbiter dut (
        .clk           (clk),
        .por_n         (por_n),
        .e_tick        (e_tick),
        .pin_in        (pin_in),
        .wdog_req      (wdog_req),
        .clkmon_req    (clkmon_req),
        .pin_drive_low (pin_drive_low),
        .sys_rst       (sys_rst),
        .rst_cause     (rst_cause)
    );

    // kind: 0 wdog, 1 clkmon, 2 both, 3 outside hold, 4 wdog+outside hold, 5 short outside pulse
    localparam logic [12:0] VEC [0:7] = '{
        {3'd0, 8'd0,  2'b10},
        {3'd1, 8'd0,  2'b11},
        {3'd2, 8'd0,  2'b10},
        {3'd3, 8'd12, 2'b01},
        {3'd4, 8'd12, 2'b01},
        {3'd5, 8'd1,  2'b01},
        {3'd1, 8'd0,  2'b11},
        {3'd3, 8'd20, 2'b01}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Follows one sequence at negedges until sys_rst drops; releases the outside hold
    // after hold_clks cycles and pulses both requests at cycle inj.
    task automatic watch(input int hold_clks, input int inj,
                         output int drv_t, output int post_t, output int rel_clks,
                         output bit low_held, output bit timeout);
        int  guard = 0;
        bit  seen = 1'b0;
        bit  released = 1'b0;
        int  left = hold_clks;
        drv_t = 0; post_t = 0; rel_clks = 0; low_held = 1'b0;
        while (!(seen && !sys_rst) && guard < 2000) begin
            wdog_req   = (guard == inj);
            clkmon_req = (guard == inj);
            if (pin_drive_low) seen = 1'b1;
            if (pin_drive_low && e_tick) drv_t++;
            if (seen && !pin_drive_low && sys_rst && e_tick) post_t++;
            if (seen && ext_low && !sys_rst) low_held = 1'b1;
            if (released) rel_clks++;
            if (ext_low) begin
                if (left <= 1) begin
                    ext_low  = 1'b0;
                    released = 1'b1;
                end else begin
                    left--;
                end
            end
            @(negedge clk);
            guard++;
        end
        wdog_req   = 1'b0;
        clkmon_req = 1'b0;
        timeout = (guard >= 2000);
    endtask

    task automatic idle_check(input int exp_cause, input string req);
        bit drove = 1'b0;
        bit rose  = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pin_drive_low) drove = 1'b1;
            if (sys_rst) rose = 1'b1;
        end
        chk(req, drove, 0);
        chk(req, rose, 0);
        chk(req, rst_cause, exp_cause);
    endtask

    task automatic run_vec(input int kind, input int hold, input int exp, input int inj);
        int    drv_t, post_t, rel_clks;
        bit    low_held, timeout;
        string tag;
        tag = (kind == 2) ? "R6" : (kind == 5) ? "R8" : (kind >= 3) ? "R4" : "R5";
        wdog_req   = (kind == 0 || kind == 2 || kind == 4);
        clkmon_req = (kind == 1 || kind == 2);
        if (kind >= 3) ext_low = 1'b1;
        @(negedge clk);
        wdog_req   = 1'b0;
        clkmon_req = 1'b0;
        watch(hold * 4, inj, drv_t, post_t, rel_clks, low_held, timeout);
        chk("R3 completion", timeout, 0);
        chk(tag, rst_cause, exp);
        chk("R2", drv_t, 4);
        if (kind == 3 || kind == 4) begin
            chk("R4 held", low_held, 0);
            chk("R4 latency", rel_clks, 2);
        end else begin
            chk("R3", post_t, 2);
        end
        idle_check(exp, (inj >= 0) ? "R7" : "R10");
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int  drv_t, post_t, rel_clks;
        bit  low_held, timeout;

        // R1: state held while power-on is active
        repeat (3) @(negedge clk);
        chk("R1 sys_rst", sys_rst, 1);
        chk("R1 drive", pin_drive_low, 1);
        chk("R1 cause", rst_cause, 0);

        // R9: sequence after power-on release, cause stays power-on
        por_n = 1'b1;
        watch(0, -1, drv_t, post_t, rel_clks, low_held, timeout);
        chk("R9 drive", drv_t, 4);
        chk("R9 wait", post_t, 2);
        chk("R9 cause", rst_cause, 0);
        idle_check(0, "R10");

        // Table walk
        for (int v = 0; v < 8; v++) begin
            run_vec(int'(VEC[v][12:10]), int'(VEC[v][9:2]), int'(VEC[v][1:0]), -1);
        end

        // R7: requests during drive, then during wait, are ignored
        run_vec(0, 0, 2, 6);
        run_vec(1, 0, 3, 19);

        // R9 + R4: power-on while the pin is held from outside
        por_n   = 1'b0;
        ext_low = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 cause", rst_cause, 0);
        por_n = 1'b1;
        watch(48, -1, drv_t, post_t, rel_clks, low_held, timeout);
        chk("R9 drive", drv_t, 4);
        chk("R9 cause", rst_cause, 0);
        chk("R4 held", low_held, 0);
        chk("R4 latency", rel_clks, 2);
        idle_check(0, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule